// File: doc/BRIEF.md
# Frame-Clock Rate Ratio Tracker

This block sits in the master-clock domain of a sample-rate converter and follows two frame clocks that run from unrelated sources: a source-side frame clock and a sink-side frame clock. It brings both into the master domain and turns each rising edge into a single-cycle event. It then counts how many source frames fall between consecutive sink frames. That coarse integer count feeds a first-order low-pass loop. The loop keeps a fixed-point estimate of source frames per sink frame whose fractional resolution is far finer than any single measurement.

Each sink frame is a request for one output sample. On each request the block advances a phase accumulator by the current estimate and reports the fractional part as a 16-bit polyphase branch index, together with a one-cycle strobe. The interpolation stage uses that index to pick the nearest of 65,536 filter phases.

A mode pin sets the loop gain. A small gain (slow mode) rejects frame-clock jitter strongly but is slow to acquire. A large gain (fast mode) follows step changes in either rate within a few frames. A lock flag reports that the loop error has stayed small for a run of consecutive requests. Because the loop is first order and has a low bandwidth, the estimate lags the true ratio while either rate is moving.

Top module: `rate_ratio_tracker`

## Requirements
- R1: While rstN is low, and right after it is released, rateRatio reads 0x00010000 (1.0 in 16.16 format), phaseIdx reads 0, and phaseValid and locked are both low.
- R2: Each rising edge of outFrame yields exactly one phaseValid pulse, one master-clock cycle long. The pulse is high in the cycle after the fourth rising clk edge, where the first edge is the first one to sample outFrame high. The frame clocks and fastMode all reach the loop with this same three-edge resampling latency.
- R3: Rising edges of inFrame are counted between consecutive outFrame events. If an inFrame event arrives in the same cycle as an outFrame event, it is counted into the frame that is closing.
- R4: On each outFrame event the error is E = N*65536 - rateRatio, where N is the count from R3. rateRatio then becomes rateRatio + (E >>> S), using an arithmetic shift. S is SLOW_SHIFT (default 6) when the resampled fastMode is low and FAST_SHIFT (default 2) when it is high.
- R5: On each outFrame event a 32-bit phase accumulator adds the rateRatio value held before that event, modulo 2^32. phaseIdx becomes bits [15:0] of the new accumulator value.
- R6: rateRatio and phaseIdx change only with a phaseValid pulse. inFrame events with no outFrame event leave both unchanged.
- R7: A good-frame counter advances, saturating at LOCK_FRAMES (default 8), on each outFrame event where |E| < LOCK_THRESH (default 0xC000). It clears on an event where |E| is at or above the threshold. locked is high exactly while the counter equals LOCK_FRAMES.
- R8: With steady frame clocks, rateRatio settles to within 0x4000 of 65536 times the true ratio of the outFrame period to the inFrame period, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inFrame | input | 1 | Source-side frame clock, asynchronous to clk |
| outFrame | input | 1 | Sink-side frame clock (output-sample request), asynchronous to clk |
| fastMode | input | 1 | High selects the wide (fast) loop bandwidth, low the narrow (slow) one |
| phaseIdx | output | 16 | Polyphase branch index for the current request |
| phaseValid | output | 1 | One-cycle strobe marking a new phaseIdx |
| rateRatio | output | 32 | Filtered source-per-sink frame ratio, 16.16 unsigned |
| locked | output | 1 | Loop error has been small for LOCK_FRAMES consecutive requests |

## Verification
The assertions assume that each frame clock stays high and stays low for at least two master cycles. Under that condition the resampled edge events can never fall in back-to-back cycles, and a lock rise always coincides with a request strobe. They also assume that no run between sink frames holds enough source frames to saturate the count, so the ratio stays below its ceiling. The stimulus uses frame periods of 5 to 60 master cycles with half-period duty. Sink-frame runs last a few thousand cycles at most, and fastMode switches only while no frame edge is in flight through the resampling stages.

// File: rtl/rate_track_pkg.sv
package rate_track_pkg;

  typedef struct packed {
    logic inEvt;
    logic outEvt;
    logic fastSel;
  } trackStrobeT;

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic risePulse
);

  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe      <= '0;
      risePulse <= 1'b0;
    end else begin
      pipe      <= {pipe[STAGES-1:0], asyncIn};
      risePulse <= pipe[STAGES-1] & ~pipe[STAGES];
    end
  end

endmodule

// File: rtl/rate_track_ctrl.sv
module rate_track_ctrl
  import rate_track_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inFrame,
  input  logic        outFrame,
  input  logic        fastMode,
  output trackStrobeT strb
);

  localparam int NUM_FRAMES = 2;

  logic [NUM_FRAMES-1:0] frameIn;
  logic [NUM_FRAMES-1:0] frameRise;
  logic [STAGES-1:0]     modePipe;
  logic                  fastReg;

  assign frameIn = {outFrame, inFrame};

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : gSync
    frame_edge_sync #(.STAGES(STAGES)) uSync (
      .clk      (clk),
      .rstN     (rstN),
      .asyncIn  (frameIn[g]),
      .risePulse(frameRise[g])
    );
  end

  // Mode level takes the same three-edge path as the frame events.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePipe <= '0;
      fastReg  <= 1'b0;
    end else begin
      modePipe <= {modePipe[STAGES-2:0], fastMode};
      fastReg  <= modePipe[STAGES-1];
    end
  end

  assign strb.inEvt   = frameRise[0];
  assign strb.outEvt  = frameRise[1];
  assign strb.fastSel = fastReg;

  // R2: a resampled request cannot repeat in the next cycle
  a_r2_out_event_gap: assert property (@(posedge clk) disable iff (!rstN)
    strb.outEvt |=> !strb.outEvt);

  // R3: same for source-side events
  a_r3_in_event_gap: assert property (@(posedge clk) disable iff (!rstN)
    strb.inEvt |=> !strb.inEvt);

endmodule

// File: rtl/rate_track_datapath.sv
module rate_track_datapath
  import rate_track_pkg::*;
#(
  parameter int          INT_W       = 16,
  parameter int          FRAC_W      = 16,
  parameter int          IDX_W       = 16,
  parameter int          CNT_W       = 16,
  parameter int          SLOW_SHIFT  = 6,
  parameter int          FAST_SHIFT  = 2,
  parameter int unsigned LOCK_THRESH = 32'h0000C000,
  parameter int          LOCK_FRAMES = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  trackStrobeT             strb,
  output logic [IDX_W-1:0]        phaseIdx,
  output logic                    phaseValid,
  output logic [INT_W+FRAC_W-1:0] rateRatio,
  output logic                    locked
);

  localparam int ACC_W = INT_W + FRAC_W;
  localparam int ERR_W = ACC_W + 2;
  localparam int LK_W  = $clog2(LOCK_FRAMES + 1);
  localparam logic [ACC_W-1:0] RATIO_ONE = ACC_W'(1) << FRAC_W;
  localparam logic [ACC_W-1:0] RATIO_MAX = ACC_W'({{CNT_W{1'b1}}, {FRAC_W{1'b0}}});

  logic [CNT_W-1:0]        inCnt;
  logic [CNT_W-1:0]        cntNow;
  logic [ACC_W-1:0]        measured;
  logic signed [ERR_W-1:0] errNow;
  logic signed [ERR_W-1:0] stepNow;
  logic [ERR_W-1:0]        errMag;
  logic                    errSmall;
  logic [ACC_W-1:0]        ratioNext;
  logic [ACC_W-1:0]        phaseAcc;
  logic [ACC_W-1:0]        phaseSum;
  logic [LK_W-1:0]         goodCnt;

  // Source frames in the closing sink frame, current-cycle event included.
  always_comb begin
    cntNow = inCnt;
    if (strb.inEvt && (inCnt != {CNT_W{1'b1}})) cntNow = inCnt + 1'b1;
  end

  always_comb begin
    measured  = ACC_W'({cntNow, {FRAC_W{1'b0}}});
    errNow    = $signed({2'b00, measured}) - $signed({2'b00, rateRatio});
    stepNow   = strb.fastSel ? (errNow >>> FAST_SHIFT) : (errNow >>> SLOW_SHIFT);
    ratioNext = rateRatio + ACC_W'(stepNow);
    errMag    = errNow[ERR_W-1] ? ERR_W'(-errNow) : ERR_W'(errNow);
    errSmall  = errMag < ERR_W'(LOCK_THRESH);
    phaseSum  = phaseAcc + rateRatio;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt      <= '0;
      rateRatio  <= RATIO_ONE;
      phaseAcc   <= '0;
      phaseIdx   <= '0;
      phaseValid <= 1'b0;
      goodCnt    <= '0;
    end else begin
      phaseValid <= strb.outEvt;
      if (strb.outEvt) begin
        inCnt     <= '0;
        rateRatio <= ratioNext;
        phaseAcc  <= phaseSum;
        phaseIdx  <= phaseSum[FRAC_W-1 -: IDX_W];
        if (!errSmall)                           goodCnt <= '0;
        else if (goodCnt != LK_W'(LOCK_FRAMES))  goodCnt <= goodCnt + 1'b1;
      end else begin
        inCnt <= cntNow;
      end
    end
  end

  assign locked = (goodCnt == LK_W'(LOCK_FRAMES));

  // R2: the request strobe is one cycle wide
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    phaseValid |=> !phaseValid);

  // R6: estimate and index hold between strobes
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !phaseValid |-> ($stable(phaseIdx) && $stable(rateRatio)));

  // R7: lock can only be gained on a request
  a_r7_lock_on_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> phaseValid);

  // R4: the loop never pushes the estimate past the largest measurable count
  a_r4_ratio_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    rateRatio <= RATIO_MAX);

endmodule

// File: rtl/rate_ratio_tracker.sv
module rate_ratio_tracker
  import rate_track_pkg::*;
#(
  parameter int          INT_W       = 16,
  parameter int          FRAC_W      = 16,
  parameter int          IDX_W       = 16,
  parameter int          CNT_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          SLOW_SHIFT  = 6,
  parameter int          FAST_SHIFT  = 2,
  parameter int unsigned LOCK_THRESH = 32'h0000C000,
  parameter int          LOCK_FRAMES = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inFrame,
  input  logic                    outFrame,
  input  logic                    fastMode,
  output logic [IDX_W-1:0]        phaseIdx,
  output logic                    phaseValid,
  output logic [INT_W+FRAC_W-1:0] rateRatio,
  output logic                    locked
);

  trackStrobeT strb;

  rate_track_ctrl #(.STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inFrame (inFrame),
    .outFrame(outFrame),
    .fastMode(fastMode),
    .strb    (strb)
  );

  rate_track_datapath #(
    .INT_W      (INT_W),
    .FRAC_W     (FRAC_W),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W),
    .SLOW_SHIFT (SLOW_SHIFT),
    .FAST_SHIFT (FAST_SHIFT),
    .LOCK_THRESH(LOCK_THRESH),
    .LOCK_FRAMES(LOCK_FRAMES)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .phaseIdx  (phaseIdx),
    .phaseValid(phaseValid),
    .rateRatio (rateRatio),
    .locked    (locked)
  );

endmodule

// File: tb/rate_ratio_tracker_test.sv
`timescale 1ns/1ps
module rate_ratio_tracker_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fastMode = 1'b0;
  logic manIn = 1'b0, manOut = 1'b0;
  logic genOn = 1'b0;
  logic genIn = 1'b0, genOut = 1'b0;
  logic inFrame, outFrame;
  logic [15:0] phaseIdx;
  logic        phaseValid;
  logic [31:0] rateRatio;
  logic        locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmpOn = 1'b0;
  int inPer = 20, outPer = 30;
  int inC = 0, outC = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  assign inFrame  = genOn ? genIn  : manIn;
  assign outFrame = genOn ? genOut : manOut;

  rate_ratio_tracker uut (
    .clk(clk), .rstN(rstN), .inFrame(inFrame), .outFrame(outFrame),
    .fastMode(fastMode), .phaseIdx(phaseIdx), .phaseValid(phaseValid),
    .rateRatio(rateRatio), .locked(locked)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Square-wave frame generators, half-period duty
  always @(negedge clk) begin
    if (!genOn) begin
      inC = 0; outC = 0;
    end else begin
      inC  = (inC + 1) % inPer;
      outC = (outC + 1) % outPer;
    end
    genIn  = (inC  < inPer / 2);
    genOut = (outC < outPer / 2);
  end

  // Behavioural reference: sample history plus the loop equations of R3..R7
  bit     inH[5], outH[5], fmH[5];
  longint mRatio = 64'h10000;
  longint mPhase = 0;
  longint mIdx = 0;
  int     mCnt = 0;
  int     mGood = 0;
  bit     mValid = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 5; i++) begin inH[i] = 0; outH[i] = 0; fmH[i] = 0; end
      mRatio = 64'h10000; mPhase = 0; mIdx = 0; mCnt = 0; mGood = 0; mValid = 0;
    end else begin
      bit inEv, outEv, fs;
      for (int i = 4; i > 0; i--) begin
        inH[i] = inH[i-1]; outH[i] = outH[i-1]; fmH[i] = fmH[i-1];
      end
      inH[0] = inFrame; outH[0] = outFrame; fmH[0] = fastMode;
      inEv  = inH[3] && !inH[4];
      outEv = outH[3] && !outH[4];
      fs    = fmH[3];
      mValid = outEv;
      if (outEv) begin
        longint n, err, absErr;
        n = mCnt + (inEv ? 1 : 0);
        if (n > 65535) n = 65535;
        err = n * 65536 - mRatio;
        absErr = (err < 0) ? -err : err;
        mPhase = (mPhase + mRatio) & 64'hFFFF_FFFF;
        mIdx   = mPhase & 64'hFFFF;
        mRatio = mRatio + (err >>> (fs ? 2 : 6));
        if (absErr < 64'hC000) mGood = (mGood < 8) ? mGood + 1 : 8;
        else mGood = 0;
        mCnt = 0;
      end else if (inEv && mCnt < 65535) begin
        mCnt = mCnt + 1;
      end
    end
  end

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      check("R2 phaseValid", phaseValid, mValid);
      check("R5 phaseIdx", phaseIdx, mIdx);
      check("R4 rateRatio", rateRatio, mRatio);
      check("R7 locked", locked, (mGood == 8));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic longint absDiff(input longint a, input longint b);
    return (a > b) ? a - b : b - a;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    // R1: values held during reset
    check("R1 ratio in reset", rateRatio, 32'h00010000);
    check("R1 idx in reset", phaseIdx, 0);
    check("R1 valid in reset", phaseValid, 0);
    check("R1 locked in reset", locked, 0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    @(negedge clk);
    check("R1 ratio after release", rateRatio, 32'h00010000);

    // R2: latency and width of the request strobe
    manOut = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R2 no early strobe", phaseValid, 0);
    end
    @(negedge clk);
    check("R2 strobe on fourth edge", phaseValid, 1);
    // R4: N=0, slow: 0x10000 + (-0x10000 >>> 6) = 0xFC00; R5: idx = 0x10000 mod 2^16
    check("R4 first slow update", rateRatio, 32'h0000FC00);
    check("R5 first index", phaseIdx, 16'h0000);
    @(negedge clk);
    check("R2 strobe one cycle", phaseValid, 0);
    manOut = 1'b0;

    // R6: source frame alone changes nothing
    repeat (3) @(negedge clk);
    manIn = 1'b1;
    repeat (10) @(negedge clk);
    check("R6 ratio held", rateRatio, 32'h0000FC00);
    check("R6 idx held", phaseIdx, 16'h0000);
    check("R6 no strobe", phaseValid, 0);

    // R3/R4/R5: one counted source frame: ratio 0xFC00 + (0x400>>>6) = 0xFC10, idx 0xFC00
    manOut = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 count one frame", rateRatio, 32'h0000FC10);
    check("R5 accumulated index", phaseIdx, 16'hFC00);
    manOut = 1'b0; manIn = 1'b0;
    repeat (4) @(negedge clk);

    // R8 slow mode, ratio 30/20 = 1.5
    inPer = 20; outPer = 30; genOn = 1'b1;
    repeat (7000) @(negedge clk);
    checks++;
    if (absDiff(rateRatio, 64'h18000) >= 64'h4000) begin
      errors++;
      $display("FAIL R8 slow settle: actual %0h expected %0h", rateRatio, 32'h18000);
    end
    check("R7 locked after settling", locked, 1);

    // R8 fast mode step to 25/40 = 0.625; mode switched with frames halted
    genOn = 1'b0;
    repeat (6) @(negedge clk);
    fastMode = 1'b1;
    repeat (6) @(negedge clk);
    inPer = 40; outPer = 25; genOn = 1'b1;
    repeat (1500) @(negedge clk);
    checks++;
    if (absDiff(rateRatio, 64'hA000) >= 64'h4000) begin
      errors++;
      $display("FAIL R8 fast settle: actual %0h expected %0h", rateRatio, 32'hA000);
    end

    // R7: a large step clears lock: ratio 60/5 = 12
    inPer = 5; outPer = 60;
    repeat (200) @(negedge clk);
    check("R7 lock lost on step", locked, 0);
    repeat (1500) @(negedge clk);
    checks++;
    if (absDiff(rateRatio, 64'hC0000) >= 64'h4000) begin
      errors++;
      $display("FAIL R8 fast high ratio: actual %0h expected %0h", rateRatio, 32'hC0000);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule